// File: doc/BRIEF.md
# Programmable Clock Divider Output Stage

This block turns one reference clock into a primary output clock and an optional secondary output clock. The primary output runs from the raw reference, from the reference halved, or from the reference divided by a 6-bit ratio. Odd and even ratios both come out with a near-symmetric duty cycle. The secondary output runs from the raw reference, from the reference halved, or from whatever the primary output is currently carrying.

A single multifunction pin is shared by three roles. It can be an output-enable input that tri-states the primary output. It can be a power-down input that stops the divider and parks both clocks low. It can also be the driver of the secondary clock. When the pin is undriven it reads high, so both input roles then leave the block in normal operation.

Every change of source is deferred to an instant where the old and the new source are both low, so the outputs never carry a shortened pulse.

Top module: `clkdiv_out_stage`

## Requirements
- R1: For an even ratio P between 2 and 62 with the divided source selected, the output period is P reference cycles and the output is high for P/2 reference cycles.
- R2: For an odd ratio P between 3 and 63 with the divided source selected, the output period is P reference cycles. The high time and the low time are each P half reference periods, which the block obtains by also using the falling reference edge.
- R3: A ratio of 0 or 1 makes the divided source equal to the undivided reference clock.
- R4: `pri_sel` chooses the primary source: 0 gives the reference, 1 gives the reference divided by 2, 2 gives the reference divided by P, and 3 acts as 0.
- R5: `sec_sel` chooses the secondary source: 0 gives the reference, 1 gives the reference divided by 2, 2 gives a copy of the primary clock, and 3 acts as 0. The secondary clock runs only in clock-output pin mode.
- R6: A source change is applied at a falling reference edge after which both the old and the new source are low. Every complete high pulse seen around a switch has the full width of either the old source or the new source.
- R7: `pin_mode` 0 (and 3) selects output-enable. In that mode a low `pin_in` drives `pri_oe` to 0, and a high `pin_in` drives it to 1.
- R8: `sec_oe` is 1 only when `pin_mode` is 2 (clock output). In every other mode, and during reset, `sec_oe` and `sec_clk` are 0.
- R9: `pin_mode` 1 selects power-down. A low `pin_in` clears the divider and holds `pri_clk` and `sec_clk` low, while `pri_oe` stays 1. After `pin_in` returns high, the first output pulse is full length, and a source change requested during power-down is applied.
- R10: A high `pin_in` in output-enable mode or power-down mode leaves the clocks running normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_p | input | 6 | Divide ratio P |
| pri_sel | input | 2 | Primary source select |
| sec_sel | input | 2 | Secondary source select |
| pin_mode | input | 2 | Multifunction pin role |
| pin_in | input | 1 | Level on the multifunction pin (high when undriven) |
| pri_clk | output | 1 | Primary clock |
| sec_clk | output | 1 | Secondary clock |
| pri_oe | output | 1 | Primary output enable (0 = tri-state) |
| sec_oe | output | 1 | Secondary output enable (pin drives clock) |

## Verification
Two events can land on the same reference cycle: a power-down request, and a pending source change on the primary output. The bench provokes this by lowering the pin and changing `pri_sel` in the same cycle. During the sleep it requires the primary output to stay flat low. After wake it requires the first pulse to have the full width of the newly chosen divided source, which proves two things: the switch completed while the divider was held cleared, and the counter restarted from zero.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic [1:0] {
    ROLE_GATE  = 2'd0,
    ROLE_SLEEP = 2'd1,
    ROLE_CLK   = 2'd2,
    ROLE_SPARE = 2'd3
  } pin_role_e;

  localparam int unsigned SRC_N = 3;

  // Select code 3 is folded onto source 0.
  function automatic logic [1:0] sel_clean(input logic [1:0] s);
    return (s == 2'd3) ? 2'd0 : s;
  endfunction

  // Ratios below 2 pass the reference straight through.
  function automatic logic ratio_bypass(input int unsigned p);
    return p < 2;
  endfunction

  // Number of full reference cycles the rising-edge stage stays high.
  function automatic int unsigned ratio_high(input int unsigned p);
    return p >> 1;
  endfunction

endpackage

// File: rtl/clkdiv_core.sv
module clkdiv_core #(
  parameter int unsigned PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [PW-1:0] div_p,
  output logic          divp_clk,
  output logic          divp_lvl,
  output logic          half_clk
);
  import clkdiv_pkg::*;

  logic [PW-1:0] cnt;
  logic [PW-1:0] hi_len;
  logic [PW-1:0] last;
  logic          pos_q, neg_q, d2_q;
  logic          bypass, odd;

  assign bypass = ratio_bypass(int'(div_p));
  assign odd    = div_p[0];
  assign hi_len = PW'(ratio_high(int'(div_p)));
  assign last   = div_p - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pos_q <= 1'b0;
      d2_q  <= 1'b0;
    end else if (clr) begin
      cnt   <= '0;
      pos_q <= 1'b0;
      d2_q  <= 1'b0;
    end else begin
      pos_q <= (cnt < hi_len);
      cnt   <= (cnt >= last) ? '0 : cnt + 1'b1;
      d2_q  <= ~d2_q;
    end
  end

  // Half-cycle retimed copy stretches odd ratios to a symmetric shape.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)   neg_q <= 1'b0;
    else if (clr) neg_q <= 1'b0;
    else          neg_q <= pos_q;
  end

  assign divp_clk = bypass ? clk : (odd ? (pos_q | neg_q) : pos_q);
  // Level held through the coming low reference phase.
  assign divp_lvl = bypass ? 1'b0 : pos_q;
  assign half_clk = d2_q;

  p_cnt_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !bypass && cnt == last) |=> (cnt == '0));

  p_clear_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && !pos_q && !d2_q));

endmodule

// File: rtl/clk_glitchless_mux.sv
module clk_glitchless_mux (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] src,
  input  logic [2:0] lvl,
  input  logic [1:0] sel_req,
  output logic       mux_clk,
  output logic       mux_lvl
);
  import clkdiv_pkg::*;

  logic [1:0] req, cur;
  logic       sw_ok;

  assign req   = sel_clean(sel_req);
  assign sw_ok = (req != cur) && !lvl[cur] && !lvl[req];

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)     cur <= 2'd0;
    else if (sw_ok) cur <= req;
  end

  assign mux_clk = src[cur];
  assign mux_lvl = lvl[cur];

  // The low phase right after a switch must show a low output.
  p_switch_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur) |-> !mux_clk);

endmodule

// File: rtl/clk_pin_ctrl.sv
module clk_pin_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pin_mode,
  input  logic       pin_in,
  output logic       sleep_q,
  output logic       pri_oe,
  output logic       clk_role
);
  import clkdiv_pkg::*;

  pin_role_e role;
  logic      sleep_req;

  assign role      = pin_role_e'(pin_mode);
  assign sleep_req = (role == ROLE_SLEEP) && !pin_in;
  assign clk_role  = (role == ROLE_CLK);
  assign pri_oe    = !(((role == ROLE_GATE) || (role == ROLE_SPARE)) && !pin_in);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sleep_q <= 1'b0;
    else        sleep_q <= sleep_req;
  end

endmodule

// File: rtl/clkdiv_out_stage.sv
module clkdiv_out_stage #(
  parameter int unsigned PW = 6
) (
  input  logic          ref_clk,
  input  logic          rst_n,
  input  logic [PW-1:0] div_p,
  input  logic [1:0]    pri_sel,
  input  logic [1:0]    sec_sel,
  input  logic [1:0]    pin_mode,
  input  logic          pin_in,
  output logic          pri_clk,
  output logic          sec_clk,
  output logic          pri_oe,
  output logic          sec_oe
);
  logic divp_clk, divp_lvl, half_clk;
  logic pri_raw, pri_lvl, sec_raw, sec_lvl;
  logic sleep_active, clk_role;

  clk_pin_ctrl u_pin (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .pin_mode (pin_mode),
    .pin_in   (pin_in),
    .sleep_q  (sleep_active),
    .pri_oe   (pri_oe),
    .clk_role (clk_role)
  );

  clkdiv_core #(.PW(PW)) u_core (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .clr      (sleep_active),
    .div_p    (div_p),
    .divp_clk (divp_clk),
    .divp_lvl (divp_lvl),
    .half_clk (half_clk)
  );

  clk_glitchless_mux u_pri_mux (
    .clk     (ref_clk),
    .rst_n   (rst_n),
    .src     ({divp_clk, half_clk, ref_clk}),
    .lvl     ({divp_lvl, half_clk, 1'b0}),
    .sel_req (pri_sel),
    .mux_clk (pri_raw),
    .mux_lvl (pri_lvl)
  );

  clk_glitchless_mux u_sec_mux (
    .clk     (ref_clk),
    .rst_n   (rst_n),
    .src     ({pri_raw, half_clk, ref_clk}),
    .lvl     ({pri_lvl, half_clk, 1'b0}),
    .sel_req (sec_sel),
    .mux_clk (sec_raw),
    .mux_lvl (sec_lvl)
  );

  assign sec_oe  = clk_role && rst_n;
  assign pri_clk = pri_raw & ~sleep_active;
  assign sec_clk = sec_raw & ~sleep_active & sec_oe;

  p_sec_quiet_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !sec_oe |-> !sec_clk);

  p_sleep_low_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    sleep_active |-> (!pri_clk && !sec_clk));

  p_sec_copy_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (sec_oe && !sec_lvl && !pri_lvl) |-> !sec_clk);

endmodule

// File: tb/clkdiv_out_stage_tb_top.sv
`timescale 1ns/1ps
module clkdiv_out_stage_tb_top;
  logic       ref_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic [5:0] div_p   = 6'd6;
  logic [1:0] pri_sel = 2'd2;
  logic [1:0] sec_sel = 2'd0;
  logic [1:0] pin_mode = 2'd0;
  logic       pin_in  = 1'b1;
  logic       pri_clk, sec_clk, pri_oe, sec_oe;

  always #2.5 ref_clk = ~ref_clk;

  clkdiv_out_stage dut_i (
    .ref_clk(ref_clk), .rst_n(rst_n), .div_p(div_p), .pri_sel(pri_sel),
    .sec_sel(sec_sel), .pin_mode(pin_mode), .pin_in(pin_in),
    .pri_clk(pri_clk), .sec_clk(sec_clk), .pri_oe(pri_oe), .sec_oe(sec_oe)
  );

  int n_run = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wrap_up;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  endtask

  // Scoreboard: expected pulse shapes, in half reference periods.
  typedef struct { bit on_sec; int hi; int lo; string tag; } exp_t;
  exp_t exp_q[$];

  task automatic push_exp(input bit s, input int h, input int l, input string t);
    exp_t e;
    e.on_sec = s; e.hi = h; e.lo = l; e.tag = t;
    exp_q.push_back(e);
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(posedge ref_clk);
  endtask

  task automatic samp(input bit s, output bit v);
    @(ref_clk);
    #1;
    v = s ? sec_clk : pri_clk;
  endtask

  task automatic measure(input exp_t e);
    bit prev, cur, found;
    int hi, lo;
    found = 0;
    samp(e.on_sec, prev);
    for (int n = 0; n < 600 && !found; n++) begin
      samp(e.on_sec, cur);
      found = !prev && cur;
      prev = cur;
    end
    if (!found) begin
      chk(0, {e.tag, " no rising edge"}, 0, 1);
      return;
    end
    for (int p = 0; p < 2; p++) begin
      hi = 1;
      samp(e.on_sec, cur);
      while (cur && hi < 600) begin hi++; samp(e.on_sec, cur); end
      lo = 1;
      samp(e.on_sec, cur);
      while (!cur && lo < 600) begin lo++; samp(e.on_sec, cur); end
      chk(hi == e.hi, {e.tag, " high"}, hi, e.hi);
      chk(lo == e.lo, {e.tag, " low"}, lo, e.lo);
    end
  endtask

  initial begin
    forever begin
      if (exp_q.size() == 0) @(posedge ref_clk);
      else begin
        measure(exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
  end

  // High-pulse width recorder for the switch checks.
  bit  win = 0, have_up = 0;
  real t_up = 0.0;
  real widths[$];
  always @(posedge pri_clk) begin t_up = $realtime; have_up = win; end
  always @(negedge pri_clk) if (win && have_up) widths.push_back($realtime - t_up);

  task automatic check_widths(input real a, input real b, input string tag);
    chk(widths.size() > 0, {tag, " pulses seen"}, widths.size(), 1);
    foreach (widths[i]) begin
      real w = widths[i];
      bit ok = ((w - a) < 0.2 && (a - w) < 0.2) || ((w - b) < 0.2 && (b - w) < 0.2);
      chk(ok, {tag, " pulse width x10ns"}, int'(w * 10.0), int'(a * 10.0));
    end
    widths.delete();
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge ref_clk);
    #0.5;
  endtask

  task automatic flat_low(input bit s, input int n, input string tag);
    int highs = 0;
    bit v;
    for (int i = 0; i < n; i++) begin samp(s, v); if (v) highs++; end
    chk(highs == 0, tag, highs, 0);
  endtask

  initial begin
    #1_000_000;
    chk(0, "watchdog expired", 0, 1);
    wrap_up();
  end

  initial begin
    cyc(3);
    chk(pri_oe == 1'b1, "R8 reset pri_oe", pri_oe, 1);
    chk(sec_oe == 1'b0, "R8 reset sec_oe", sec_oe, 0);
    flat_low(1, 6, "R8 reset sec_clk");
    @(negedge ref_clk); #1 rst_n = 1'b1;
    cyc(20);

    // R1 even ratios
    push_exp(0, 6, 6, "R1 P=6"); drain();
    div_p = 6'd4; cyc(10); push_exp(0, 4, 4, "R1 P=4"); drain();
    div_p = 6'd62; cyc(70); push_exp(0, 62, 62, "R1 P=62"); drain();
    // R2 odd ratios
    div_p = 6'd5; cyc(70); push_exp(0, 5, 5, "R2 P=5"); drain();
    div_p = 6'd3; cyc(10); push_exp(0, 3, 3, "R2 P=3"); drain();
    div_p = 6'd63; cyc(10); push_exp(0, 63, 63, "R2 P=63"); drain();
    // R3 pass-through
    div_p = 6'd1; cyc(70); push_exp(0, 1, 1, "R3 P=1"); drain();
    div_p = 6'd0; cyc(5); push_exp(0, 1, 1, "R3 P=0"); drain();
    // R4 primary select codes
    div_p = 6'd6;
    pri_sel = 2'd0; cyc(20); push_exp(0, 1, 1, "R4 sel ref"); drain();
    pri_sel = 2'd1; cyc(10); push_exp(0, 2, 2, "R4 sel half"); drain();
    pri_sel = 2'd3; cyc(10); push_exp(0, 1, 1, "R4 sel 3 as ref"); drain();
    pri_sel = 2'd2; cyc(10); push_exp(0, 6, 6, "R4 sel div"); drain();

    // R5 secondary output in clock role
    pin_mode = 2'd2; cyc(2);
    chk(sec_oe == 1'b1, "R8 sec_oe in clock role", sec_oe, 1);
    sec_sel = 2'd1; cyc(10); push_exp(1, 2, 2, "R5 sec half"); drain();
    sec_sel = 2'd0; cyc(10); push_exp(1, 1, 1, "R5 sec ref"); drain();
    div_p = 6'd7; sec_sel = 2'd2; cyc(20);
    push_exp(1, 7, 7, "R5 sec copies primary"); drain();
    push_exp(0, 7, 7, "R5 primary unchanged"); drain();

    // R6 switches requested while the old source is high
    div_p = 6'd8; cyc(30);
    win = 1;
    wait (pri_clk == 1'b1); #0.5 pri_sel = 2'd1;
    cyc(40); win = 0; check_widths(20.0, 5.0, "R6 div8 to half");
    div_p = 6'd3; cyc(10);
    win = 1;
    wait (pri_clk == 1'b1); #0.5 pri_sel = 2'd2;
    cyc(40); win = 0; check_widths(5.0, 7.5, "R6 half to div3");

    // R7 gating role
    pin_mode = 2'd0; cyc(2);
    chk(sec_oe == 1'b0, "R8 sec_oe in gating role", sec_oe, 0);
    flat_low(1, 12, "R8 sec_clk in gating role");
    pin_in = 1'b0; #1;
    chk(pri_oe == 1'b0, "R7 pin low tri-states", pri_oe, 0);
    pin_mode = 2'd3; #1;
    chk(pri_oe == 1'b0, "R7 mode 3 acts as gating", pri_oe, 0);
    pin_mode = 2'd0; pin_in = 1'b1; #1;
    chk(pri_oe == 1'b1, "R7 pin high enables", pri_oe, 1);
    push_exp(0, 3, 3, "R10 gating role pin high runs"); drain();

    // R9/R10 sleep role, with a select change in the same cycle
    div_p = 6'd6; pri_sel = 2'd1; pin_mode = 2'd1; cyc(10);
    chk(sec_oe == 1'b0, "R8 sec_oe in sleep role", sec_oe, 0);
    push_exp(0, 2, 2, "R10 sleep role pin high runs"); drain();
    cyc(1);
    pin_in = 1'b0; pri_sel = 2'd2;
    cyc(2);
    flat_low(0, 20, "R9 primary low while asleep");
    chk(pri_oe == 1'b1, "R9 pri_oe kept during sleep", pri_oe, 1);
    push_exp(0, 6, 6, "R9 first pulse after wake");
    cyc(2);
    pin_in = 1'b1;
    drain();

    cyc(5);
    wrap_up();
  end
endmodule